// File: doc/BRIEF.md
# Multiplexed-Address Dynamic Memory with Self-Refresh

This block is a dynamic-memory style storage array with its own controller. A row address and a column address arrive one after the other on the same address pins. The row strobe opens a row and the column strobe selects a word inside it. Opening a row empties the array row into a row buffer, because the read is destructive. Column reads and writes then work on that buffer. When the row strobe drops, the buffer is written back to the array.

Stored rows age. Each row has a counter that grows every cycle the row is neither open nor refreshed. A row left alone for longer than the retention limit loses its contents, which are replaced by a fixed corrupt word. A refresh engine restores the next row in turn every refresh interval, but only while no row is open. This keeps every row inside its retention limit under normal traffic.

Top module: `dram_core`

## Requirements
- R1: At a cycle where the row strobe opens a row, the row index is taken from the low ROW_W bits of `addr_i`. At a column access, the word index is taken from the low COL_W bits of `addr_i`, and higher address bits are ignored.
- R2: While a row is open, a cycle with `col_stb_i` and `we_i` high stores `wdata_i` into the selected word, and `rvalid_o` is low in the following cycle.
- R3: While a row is open, a cycle with `col_stb_i` high and `we_i` low puts the selected word on `rdata_o` in the next cycle, with `rvalid_o` high for that one cycle.
- R4: `col_stb_i` while no row is open is ignored: nothing is stored and `rvalid_o` stays low.
- R5: Data survives any number of destructive open/read/close sessions on the same or other rows.
- R6: A cycle with `row_stb_i` low closes the open row and writes it back. A different row can be opened in the next cycle with `row_stb_i` high.
- R7: While `refresh_en_i` is high, a refresh request is raised every REFRESH_INTERVAL cycles. It is served only in a cycle with no open row and `row_stb_i` low, and it restores rows in ascending order, wrapping after the last row. The refresh pointer moves only when a request is served.
- R8: With refresh enabled and normal traffic, including long idle stretches, no row is ever corrupted.
- R9: With `refresh_en_i` low, every word of a row not accessed for more than RETENTION cycles reads back as CORRUPT_WORD (default 16'hDEAD). No age counter exceeds RETENTION.
- R10: After reset, `rvalid_o` and `rdata_o` are 0 and every stored word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | max(ROW_W,COL_W) | Shared row/column address |
| row_stb_i | input | 1 | Row strobe: rising opens a row, low closes it |
| col_stb_i | input | 1 | Column strobe: one access per cycle high |
| we_i | input | 1 | Write enable for the column access |
| wdata_i | input | DATA_W | Write data |
| refresh_en_i | input | 1 | Enables the refresh engine |
| rdata_o | output | DATA_W | Read data |
| rvalid_o | output | 1 | Read data valid, one cycle per read |

## Verification
The hardest situation to reach is decay. With the default sizes it needs more than a thousand cycles with no refresh and no access to the row. Any column traffic or refresh hides it. The bench turns `refresh_en_i` off, idles past the retention limit, and then reads rows expecting the corrupt word. The opposite case needs a long idle stretch with refresh on, so that the pointer wraps several times; the bench then sweeps every word of every row.

// File: rtl/dram_pkg.sv
package dram_pkg;
   // Larger of two widths, used to size the shared address pins.
   function automatic int unsigned max_w(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
   parameter int unsigned ROW_W    = 6,
   parameter int unsigned INTERVAL = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             enable_i,
   input  logic             allow_i,
   output logic             go_o,
   output logic [ROW_W-1:0] row_o
);
   localparam int unsigned ROWS  = 1 << ROW_W;
   localparam int unsigned CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

   logic [CNT_W-1:0] cnt_q;
   logic             pending_q;
   logic             tick;

   assign tick = enable_i && (cnt_q == CNT_W'(INTERVAL - 1));
   assign go_o = pending_q && allow_i && enable_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q     <= '0;
         pending_q <= 1'b0;
         row_o     <= '0;
      end else begin
         if (enable_i) cnt_q <= tick ? '0 : cnt_q + 1'b1;
         if (tick)      pending_q <= 1'b1;
         else if (go_o) pending_q <= 1'b0;
         if (go_o) row_o <= (row_o == ROW_W'(ROWS - 1)) ? '0 : row_o + 1'b1;
      end
   end

   // R7
   ptr_moves_only_on_service_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(go_o) |-> $stable(row_o));
   // R7
   request_not_dropped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pending_q) |-> $past(go_o));
endmodule

// File: rtl/dram_age_tracker.sv
module dram_age_tracker #(
   parameter int unsigned ROWS      = 64,
   parameter int unsigned RETENTION = 1200
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [ROWS-1:0] clr_i,
   output logic [ROWS-1:0] expired_o
);
   localparam int unsigned AGE_W = $clog2(RETENTION + 1);

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic [AGE_W-1:0] age_q;

      always_ff @(posedge clk_i) begin
         if (!rst_ni || clr_i[r]) age_q <= '0;
         else if (age_q != AGE_W'(RETENTION)) age_q <= age_q + 1'b1;
      end

      assign expired_o[r] = (age_q == AGE_W'(RETENTION));

      // R9
      age_bounded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         age_q <= AGE_W'(RETENTION));
   end
endmodule

// File: rtl/dram_row_buffer.sv
module dram_row_buffer #(
   parameter int unsigned COL_W  = 3,
   parameter int unsigned DATA_W = 16
) (
   input  logic                              clk_i,
   input  logic                              rst_ni,
   input  logic                              load_i,
   input  logic [(1<<COL_W)*DATA_W-1:0]      load_data_i,
   input  logic                              access_i,
   input  logic                              we_i,
   input  logic [COL_W-1:0]                  col_i,
   input  logic [DATA_W-1:0]                 wdata_i,
   output logic [(1<<COL_W)*DATA_W-1:0]      row_o,
   output logic [DATA_W-1:0]                 rdata_o,
   output logic                              rvalid_o
);
   localparam int unsigned WORDS = 1 << COL_W;

   logic [DATA_W-1:0] word_q [WORDS];

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      assign row_o[w*DATA_W +: DATA_W] = word_q[w];
      always_ff @(posedge clk_i) begin
         if (!rst_ni) word_q[w] <= '0;
         else if (load_i) word_q[w] <= load_data_i[w*DATA_W +: DATA_W];
         else if (access_i && we_i && (col_i == COL_W'(w))) word_q[w] <= wdata_i;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rdata_o  <= '0;
         rvalid_o <= 1'b0;
      end else begin
         rvalid_o <= access_i && !we_i;
         if (access_i && !we_i) rdata_o <= word_q[col_i];
      end
   end

   // R2
   write_gives_no_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (access_i && we_i) |=> !rvalid_o);
   // R3
   read_valid_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rvalid_o |-> $past(access_i && !we_i));
endmodule

// File: rtl/dram_core.sv
module dram_core #(
   parameter int unsigned ROW_W            = 6,
   parameter int unsigned COL_W            = 3,
   parameter int unsigned DATA_W           = 16,
   parameter int unsigned REFRESH_INTERVAL = 8,
   parameter int unsigned RETENTION        = 1200,
   parameter logic [DATA_W-1:0] CORRUPT_WORD = 16'hDEAD,
   localparam int unsigned ADDR_W = dram_pkg::max_w(ROW_W, COL_W)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              row_stb_i,
   input  logic              col_stb_i,
   input  logic              we_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              refresh_en_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              rvalid_o
);
   localparam int unsigned ROWS     = 1 << ROW_W;
   localparam int unsigned WORDS    = 1 << COL_W;
   localparam int unsigned ROW_BITS = WORDS * DATA_W;

   if (ROW_W < 1 || COL_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("dram_core: widths must be at least 1");
   end
   if (REFRESH_INTERVAL < 2) begin : g_bad_interval
      $error("dram_core: REFRESH_INTERVAL must be at least 2");
   end
   if (RETENTION <= ROWS * REFRESH_INTERVAL) begin : g_bad_retention
      $error("dram_core: RETENTION must exceed one full refresh sweep");
   end

   logic [ROW_BITS-1:0] array_q [ROWS];
   logic                row_open_q;
   logic [ROW_W-1:0]    row_q;
   logic [ROW_W-1:0]    row_addr;
   logic [COL_W-1:0]    col_addr;
   logic                open_go, close_go;
   logic                ref_go;
   logic [ROW_W-1:0]    ref_row;
   logic [ROWS-1:0]     age_clr, expired;
   logic [ROW_BITS-1:0] buf_row;

   assign row_addr = addr_i[ROW_W-1:0];
   assign col_addr = addr_i[COL_W-1:0];
   assign open_go  = row_stb_i && !row_open_q;
   assign close_go = row_open_q && !row_stb_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         row_open_q <= 1'b0;
         row_q      <= '0;
      end else if (open_go) begin
         row_open_q <= 1'b1;
         row_q      <= row_addr;
      end else if (close_go) begin
         row_open_q <= 1'b0;
      end
   end

   // Array: restore on close, destroy on open, decay when expired.
   always_ff @(posedge clk_i) begin
      for (int r = 0; r < ROWS; r++) begin
         if (!rst_ni) array_q[r] <= '0;
         else if (close_go && row_q == ROW_W'(r)) array_q[r] <= buf_row;
         else if (open_go && row_addr == ROW_W'(r)) array_q[r] <= '0;
         else if (expired[r]) array_q[r] <= {WORDS{CORRUPT_WORD}};
      end
   end

   always_comb begin
      for (int r = 0; r < ROWS; r++) begin
         age_clr[r] = (row_open_q && row_q == ROW_W'(r))
                   || (open_go && row_addr == ROW_W'(r))
                   || (ref_go && ref_row == ROW_W'(r));
      end
   end

   dram_refresh_timer #(.ROW_W(ROW_W), .INTERVAL(REFRESH_INTERVAL)) u_refresh (
      .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(refresh_en_i),
      .allow_i(!row_open_q && !row_stb_i), .go_o(ref_go), .row_o(ref_row));

   dram_age_tracker #(.ROWS(ROWS), .RETENTION(RETENTION)) u_age (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(age_clr), .expired_o(expired));

   dram_row_buffer #(.COL_W(COL_W), .DATA_W(DATA_W)) u_buf (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(open_go), .load_data_i(array_q[row_addr]),
      .access_i(col_stb_i && row_open_q), .we_i(we_i), .col_i(col_addr),
      .wdata_i(wdata_i), .row_o(buf_row), .rdata_o(rdata_o), .rvalid_o(rvalid_o));

   // R4
   stray_col_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (col_stb_i && !row_open_q) |=> !rvalid_o);
   // R7
   refresh_row_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ref_go |-> !row_open_q);
   // R6
   open_after_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(row_open_q) && !row_open_q) |-> $past(!row_stb_i));
endmodule

// File: tb/dram_core_bench.sv
module dram_core_bench;
   localparam int CLK_PERIOD = 10;
   localparam int ROW_W = 6, COL_W = 3, DATA_W = 16;
   localparam int ROWS = 1 << ROW_W, WORDS = 1 << COL_W;
   localparam int INTERVAL = 8, RETENTION = 1200;
   localparam logic [15:0] CORRUPT = 16'hDEAD;

   logic clk = 0, rst_n = 0;
   logic [5:0] addr = '0;
   logic row_stb = 0, col_stb = 0, we = 0, ref_en = 1;
   logic [15:0] wdata = '0, rdata;
   logic rvalid;
   int tests = 0, fails = 0;
   logic [15:0] model [ROWS][WORDS];

   always #(CLK_PERIOD/2) clk = ~clk;

   dram_core u_dram_core (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .row_stb_i(row_stb),
      .col_stb_i(col_stb), .we_i(we), .wdata_i(wdata), .refresh_en_i(ref_en),
      .rdata_o(rdata), .rvalid_o(rvalid));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic open_row(input int r);
      row_stb = 1; addr = 6'(r); col_stb = 0;
      @(negedge clk);
   endtask

   task automatic close_row();
      row_stb = 0; col_stb = 0;
      @(negedge clk);
      @(negedge clk);
   endtask

   // One column access; the read result is registered at the next edge.
   task automatic col_op(input string req, input int r, input int c, input logic w,
                         input logic [15:0] d, input logic [5:0] hi);
      col_stb = 1; we = w; wdata = d; addr = hi | 6'(c);
      @(negedge clk);
      if (w) begin
         model[r][c] = d;
         chk({req, " write rvalid"}, 32'(rvalid), 32'd0);
      end else begin
         chk({req, " read rvalid"}, 32'(rvalid), 32'd1);
         chk({req, " read data"}, 32'(rdata), 32'(model[r][c]));
      end
      col_stb = 0; we = 0;
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4242));
      for (int r = 0; r < ROWS; r++) for (int c = 0; c < WORDS; c++) model[r][c] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R10: reset state
      chk("R10 rvalid", 32'(rvalid), 0);
      chk("R10 rdata", 32'(rdata), 0);
      open_row(5); col_op("R10", 5, 3, 0, '0, '0); close_row();

      // R1: high address bits ignored for the column
      open_row(9);
      col_op("R1", 9, 2, 1, 16'h1234, 6'b101000);
      col_op("R1", 9, 2, 0, '0, 6'b010000);
      col_op("R3", 9, 7, 0, '0, '0);
      close_row();

      // R4: column strobe with no open row
      col_stb = 1; we = 1; wdata = 16'hFFFF; addr = 6'd2;
      @(negedge clk);
      chk("R4 stray write rvalid", 32'(rvalid), 0);
      we = 0;
      @(negedge clk);
      chk("R4 stray read rvalid", 32'(rvalid), 0);
      col_stb = 0;
      open_row(9); col_op("R4", 9, 2, 0, '0, '0); close_row();
      open_row(2); col_op("R4", 2, 2, 0, '0, '0); close_row();

      // R6: close, then another row, then back
      open_row(12); col_op("R6", 12, 0, 1, 16'hA0A0, '0);
      row_stb = 0; @(negedge clk);
      open_row(13); col_op("R6", 13, 0, 1, 16'hB1B1, '0); close_row();
      open_row(12); col_op("R6", 12, 0, 0, '0, '0); close_row();

      // R2 R3 R5: random sessions
      for (int s = 0; s < 300; s++) begin
         int r = int'($urandom_range(ROWS - 1));
         int n = int'($urandom_range(4, 1));
         open_row(r);
         for (int k = 0; k < n; k++) begin
            int c = int'($urandom_range(WORDS - 1));
            logic w = 1'($urandom_range(1));
            col_op(w ? "R2" : "R5", r, c, w, 16'($urandom), 6'($urandom_range(7)) << 3);
         end
         close_row();
      end

      // R7 R8: long idle with refresh, then sweep everything
      repeat (3 * RETENTION) @(negedge clk);
      for (int r = 0; r < ROWS; r++) begin
         open_row(r);
         for (int c = 0; c < WORDS; c++) col_op("R8 R7", r, c, 0, '0, '0);
         close_row();
      end

      // R9: refresh off, wait past retention
      ref_en = 0;
      repeat (RETENTION + 20) @(negedge clk);
      for (int r = 0; r < ROWS; r++) for (int c = 0; c < WORDS; c++) model[r][c] = CORRUPT;
      for (int r = 0; r < 4; r++) begin
         open_row(r * 17);
         for (int c = 0; c < WORDS; c++) col_op("R9", r * 17, c, 0, '0, '0);
         close_row();
      end
      ref_en = 1;
      open_row(30); col_op("R9", 30, 1, 1, 16'h5A5A, '0); close_row();
      open_row(30); col_op("R9", 30, 1, 0, '0, '0); close_row();
      finish_run();
   end
endmodule